// File: doc/BRIEF.md
# Dual-Edge Pipelined FIR Filter

This block is a four-tap, third-order direct-form FIR filter with a fully parallel pipeline. Every clock cycle it can accept one signed sample. It keeps the three previous accepted samples in a shift chain, multiplies all four samples by their coefficients in parallel, and sums the products in a two-level adder tree. The result comes out together with a valid flag.

The pipeline has four register stages: sample capture, products, pair sums and the final sum. A parameter chooses how those stages are clocked. In dual-edge mode, neighbouring stages alternate between the rising and the falling clock edge. The latency from sample capture to result is then 1.5 clock cycles instead of 3, and the clock frequency does not change. In single-edge mode all stages use the rising edge, which gives the conventional 3-cycle pipeline as a baseline. The coefficients come in on a flat input bus and must be held stable while samples are in flight.

Top module: `dual_edge_fir`

## Requirements
- R1: When the filter receives an accepted sample x(n), the matching result is h0·x(n) + h1·x(n−1) + h2·x(n−2) + h3·x(n−3). The result is computed in two's complement at full precision on a 34-bit output. Coefficient hk sits at `coefs[16k+15:16k]`. Samples and coefficients are 16-bit signed.
- R2: A sample is accepted only on a rising edge where `in_valid` is high. Cycles where `in_valid` is low do not shift the sample history, whatever `in_x` carries.
- R3: In dual-edge mode (`DUAL_EDGE=1`), the result for a sample captured at rising edge k appears on `out_y` at the falling edge 1.5 cycles later, with `out_valid` high.
- R4: In single-edge mode (`DUAL_EDGE=0`), the result for a sample captured at rising edge k appears at rising edge k+3.
- R5: `out_valid` is high for exactly one output update per accepted sample, and it is aligned with that sample's result.
- R6: While `out_valid` is low, `out_y` holds the last result.
- R7: A synchronous active-high `rst` clears the sample history and every pipeline and valid register on both edges. Afterwards `out_y` is 0 and `out_valid` is 0, and the first results after reset use zero for older samples.
- R8: Full-scale inputs do not overflow. All samples and coefficients at −32768 give +2^32, and samples at +32767 with coefficients at −32768 give −4·32767·32768.
- R9: Back-to-back valid samples, one per cycle, each produce a correct result, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used in dual-edge mode |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_x | input | 16 | Signed input sample |
| coefs | input | 64 | Four signed 16-bit coefficients, h0 in the low bits |
| out_valid | output | 1 | Result valid flag |
| out_y | output | 34 | Signed filter result |

## Verification
Some behaviour is checked by assertions on every cycle. These cover the valid latency in the selected mode, the holding of `out_y` while no result is valid, the holding of each stage register while its enable is low, and the bound on the output magnitude. Other behaviour only the bench scenarios can show, because it needs a reference sum over the accepted sample history. This covers the arithmetic result for streams with and without gaps, the effect of gaps on the history, the zero history after reset and the extreme-value sums. The bench runs one instance of each mode side by side on the same stimulus.

// File: rtl/fir_de_pkg.sv
package fir_de_pkg;

   // Register stages from sample capture to result.
   localparam int FIR_STAGES = 4;

   // Stage s clocks on the falling edge only in dual-edge mode, and only on odd stages.
   function automatic bit stage_on_fall(input bit dual, input int stage);
      return dual && ((stage % 2) == 1);
   endfunction

   // Input-valid to output-valid distance, counted in rising-edge samples.
   function automatic int valid_lag(input bit dual);
      return dual ? 2 : 4;
   endfunction

endpackage

// File: rtl/edge_pipe_reg.sv
module edge_pipe_reg #(
   parameter int W       = 8,
   parameter bit ON_FALL = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("edge_pipe_reg: W must be at least 1");
   end

   if (ON_FALL) begin : g_fall
      always_ff @(negedge clk) begin
         if (rst)     q <= '0;
         else if (en) q <= d;
      end
      // R2 / R6: a stage register with its enable low keeps its contents
      assert_stage_hold_R6: assert property (@(negedge clk) disable iff (rst)
         !en |=> $stable(q));
   end else begin : g_rise
      always_ff @(posedge clk) begin
         if (rst)     q <= '0;
         else if (en) q <= d;
      end
      // R2 / R6: a stage register with its enable low keeps its contents
      assert_stage_hold_R6: assert property (@(posedge clk) disable iff (rst)
         !en |=> $stable(q));
   end

endmodule

// File: rtl/fir_tap_chain.sv
module fir_tap_chain #(
   parameter int DATA_W = 16,
   parameter int TAPS   = 4
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   shift_en,
   input  logic [DATA_W-1:0]      din,
   output logic [TAPS*DATA_W-1:0] taps
);

   // Slot 0 is the capture register; slot k holds the sample accepted k samples earlier.
   for (genvar k = 0; k < TAPS; k++) begin : g_slot
      logic [DATA_W-1:0] slot_d;
      if (k == 0) begin : g_head
         assign slot_d = din;
      end else begin : g_body
         assign slot_d = taps[(k-1)*DATA_W +: DATA_W];
      end
      edge_pipe_reg #(.W(DATA_W), .ON_FALL(1'b0)) u_slot (
         .clk (clk),
         .rst (rst),
         .en  (shift_en),
         .d   (slot_d),
         .q   (taps[k*DATA_W +: DATA_W])
      );
   end

endmodule

// File: rtl/fir_product_stage.sv
module fir_product_stage #(
   parameter int DATA_W  = 16,
   parameter int COEF_W  = 16,
   parameter int TAPS    = 4,
   parameter bit ON_FALL = 1'b1,
   localparam int PROD_W = DATA_W + COEF_W
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   en,
   input  logic [TAPS*DATA_W-1:0] taps,
   input  logic [TAPS*COEF_W-1:0] coefs,
   output logic [TAPS*PROD_W-1:0] prods
);

   for (genvar k = 0; k < TAPS; k++) begin : g_mul
      logic signed [DATA_W-1:0] xs;
      logic signed [COEF_W-1:0] hs;
      logic signed [PROD_W-1:0] pk;
      assign xs = taps[k*DATA_W +: DATA_W];
      assign hs = coefs[k*COEF_W +: COEF_W];
      assign pk = PROD_W'(xs) * PROD_W'(hs);
      edge_pipe_reg #(.W(PROD_W), .ON_FALL(ON_FALL)) u_prod (
         .clk (clk),
         .rst (rst),
         .en  (en),
         .d   (pk),
         .q   (prods[k*PROD_W +: PROD_W])
      );
   end

endmodule

// File: rtl/fir_pair_stage.sv
module fir_pair_stage #(
   parameter int PROD_W  = 32,
   parameter int TAPS    = 4,
   parameter bit ON_FALL = 1'b0,
   localparam int PAIRS  = TAPS / 2,
   localparam int PAIR_W = PROD_W + 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [TAPS*PROD_W-1:0]  prods,
   output logic [PAIRS*PAIR_W-1:0] pairs
);

   for (genvar j = 0; j < PAIRS; j++) begin : g_pair
      logic signed [PROD_W-1:0] lo;
      logic signed [PROD_W-1:0] hi;
      logic signed [PAIR_W-1:0] sj;
      assign lo = prods[(2*j)*PROD_W   +: PROD_W];
      assign hi = prods[(2*j+1)*PROD_W +: PROD_W];
      assign sj = PAIR_W'(lo) + PAIR_W'(hi);
      edge_pipe_reg #(.W(PAIR_W), .ON_FALL(ON_FALL)) u_sum (
         .clk (clk),
         .rst (rst),
         .en  (en),
         .d   (sj),
         .q   (pairs[j*PAIR_W +: PAIR_W])
      );
   end

endmodule

// File: rtl/fir_final_stage.sv
module fir_final_stage #(
   parameter int PAIR_W  = 33,
   parameter int PAIRS   = 2,
   parameter int ACC_W   = 34,
   parameter bit ON_FALL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [PAIRS*PAIR_W-1:0] pairs,
   output logic [ACC_W-1:0]        acc_q
);

   if (ACC_W < PAIR_W) begin : g_bad_acc
      $error("fir_final_stage: ACC_W narrower than a pair sum");
   end

   logic signed [PAIR_W-1:0] pr [PAIRS];
   logic signed [ACC_W-1:0]  acc_d;

   for (genvar j = 0; j < PAIRS; j++) begin : g_unpack
      assign pr[j] = pairs[j*PAIR_W +: PAIR_W];
   end

   always_comb begin
      acc_d = '0;
      for (int j = 0; j < PAIRS; j++) begin
         acc_d = acc_d + ACC_W'(pr[j]);
      end
   end

   edge_pipe_reg #(.W(ACC_W), .ON_FALL(ON_FALL)) u_acc (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .d   (acc_d),
      .q   (acc_q)
   );

endmodule

// File: rtl/dual_edge_fir.sv
module dual_edge_fir
   import fir_de_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int COEF_W    = 16,
   parameter int TAPS      = 4,
   parameter bit DUAL_EDGE = 1'b1,
   localparam int PROD_W   = DATA_W + COEF_W,
   localparam int ACC_W    = PROD_W + $clog2(TAPS)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [DATA_W-1:0]      in_x,
   input  logic [TAPS*COEF_W-1:0] coefs,
   output logic                   out_valid,
   output logic [ACC_W-1:0]       out_y
);

   localparam int PAIRS  = TAPS / 2;
   localparam int PAIR_W = PROD_W + 1;
   localparam int LAG    = valid_lag(DUAL_EDGE);

   if (TAPS < 4 || (TAPS % 2) != 0) begin : g_bad_taps
      $error("dual_edge_fir: TAPS must be even and at least 4");
   end
   if (DATA_W < 2 || COEF_W < 2) begin : g_bad_width
      $error("dual_edge_fir: sample and coefficient widths must be at least 2");
   end

   // vld[s] qualifies the input of stage s; vld[FIR_STAGES] is the output flag.
   logic [FIR_STAGES:0]      vld;
   logic [TAPS*DATA_W-1:0]   taps;
   logic [TAPS*PROD_W-1:0]   prods;
   logic [PAIRS*PAIR_W-1:0]  pairs;

   assign vld[0] = in_valid;

   for (genvar s = 0; s < FIR_STAGES; s++) begin : g_vld
      edge_pipe_reg #(.W(1), .ON_FALL(stage_on_fall(DUAL_EDGE, s))) u_v (
         .clk (clk),
         .rst (rst),
         .en  (1'b1),
         .d   (vld[s]),
         .q   (vld[s+1])
      );
   end

   fir_tap_chain #(.DATA_W(DATA_W), .TAPS(TAPS)) u_taps (
      .clk      (clk),
      .rst      (rst),
      .shift_en (vld[0]),
      .din      (in_x),
      .taps     (taps)
   );

   fir_product_stage #(
      .DATA_W  (DATA_W),
      .COEF_W  (COEF_W),
      .TAPS    (TAPS),
      .ON_FALL (stage_on_fall(DUAL_EDGE, 1))
   ) u_prod (
      .clk   (clk),
      .rst   (rst),
      .en    (vld[1]),
      .taps  (taps),
      .coefs (coefs),
      .prods (prods)
   );

   fir_pair_stage #(
      .PROD_W  (PROD_W),
      .TAPS    (TAPS),
      .ON_FALL (stage_on_fall(DUAL_EDGE, 2))
   ) u_pair (
      .clk   (clk),
      .rst   (rst),
      .en    (vld[2]),
      .prods (prods),
      .pairs (pairs)
   );

   fir_final_stage #(
      .PAIR_W  (PAIR_W),
      .PAIRS   (PAIRS),
      .ACC_W   (ACC_W),
      .ON_FALL (stage_on_fall(DUAL_EDGE, 3))
   ) u_final (
      .clk   (clk),
      .rst   (rst),
      .en    (vld[3]),
      .pairs (pairs),
      .acc_q (out_y)
   );

   assign out_valid = vld[FIR_STAGES];

   // ---------------- assertions ----------------
   // Count of rising edges since reset, saturating, used to keep $past inside post-reset history.
   logic [2:0] rst_age;
   always_ff @(posedge clk) begin
      if (rst)                rst_age <= '0;
      else if (rst_age != '1) rst_age <= rst_age + 3'd1;
   end

   localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'(TAPS) <<< (PROD_W - 2);
   logic signed [ACC_W-1:0] y_s;
   assign y_s = out_y;

   if (DUAL_EDGE) begin : g_lat_dual
      // R3: the output flag follows the input strobe by 1.5 cycles (two rising samples)
      assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
         (int'(rst_age) > LAG) |-> (out_valid == $past(in_valid, 2)));
   end else begin : g_lat_single
      // R4: the output flag follows the input strobe by 3 cycles (four rising samples)
      assert_valid_latency_R4: assert property (@(posedge clk) disable iff (rst)
         (int'(rst_age) > LAG) |-> (out_valid == $past(in_valid, 4)));
   end

   // R6: result holds while no result is valid
   assert_output_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (rst_age != '0 && !out_valid) |-> $stable(out_y));

   // R8: a valid result stays within the full-scale bound of TAPS products
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (y_s <= OUT_MAX && y_s >= -OUT_MAX));

endmodule

// File: tb/test_dual_edge_fir.sv
module test_dual_edge_fir;

   localparam int DW = 16;
   localparam int CW = 16;
   localparam int NT = 4;
   localparam int AW = DW + CW + 2;
   localparam int NV = 24;
   localparam int HIST = 512;

   // {valid, sample}
   localparam logic [16:0] VEC [NV] = '{
      {1'b1, 16'h0001}, {1'b1, 16'h0002}, {1'b1, 16'h0003}, {1'b1, 16'h0004},
      {1'b1, 16'hFFFF}, {1'b1, 16'hFF9C}, {1'b1, 16'h03E8}, {1'b1, 16'h7FFF},
      {1'b1, 16'h8000}, {1'b1, 16'h0000}, {1'b1, 16'h0005}, {1'b1, 16'hFFF9},
      {1'b0, 16'h04D2}, {1'b1, 16'h000A}, {1'b0, 16'h270F}, {1'b0, 16'h1111},
      {1'b1, 16'hFFEC}, {1'b1, 16'h001E}, {1'b0, 16'h7FFF}, {1'b1, 16'h0028},
      {1'b0, 16'h8000}, {1'b1, 16'hFFCE}, {1'b0, 16'h0101}, {1'b1, 16'h003C}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_x = '0;
   logic [NT*CW-1:0] coefs = '0;
   logic          v_d, v_s;
   logic signed [AW-1:0] y_d, y_s;

   always #10 clk = ~clk;

   dual_edge_fir #(.DATA_W(DW), .COEF_W(CW), .TAPS(NT), .DUAL_EDGE(1'b1)) i_dual_edge_fir (
      .clk (clk), .rst (rst), .in_valid (in_valid), .in_x (in_x),
      .coefs (coefs), .out_valid (v_d), .out_y (y_d)
   );

   dual_edge_fir #(.DATA_W(DW), .COEF_W(CW), .TAPS(NT), .DUAL_EDGE(1'b0)) i_dual_edge_fir_single (
      .clk (clk), .rst (rst), .in_valid (in_valid), .in_x (in_x),
      .coefs (coefs), .out_valid (v_s), .out_y (y_s)
   );

   int     n_chk = 0;
   int     n_bad = 0;
   bit     done  = 1'b0;
   int     iter  = 0;
   int     resume_at = 4;
   longint h [NT];
   longint hist [NT];
   longint last_y = 0;
   longint exp_y [HIST];
   bit     exp_v [HIST];
   string  ytag  = "R1";
   string  vtag_d = "R3";
   string  vtag_s = "R4";

   task automatic check(input string req, input longint act, input longint expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (step %0d)", req, act, expv, iter);
      end
   endtask

   task automatic load_coefs(input longint c0, input longint c1, input longint c2, input longint c3);
      h[0] = c0; h[1] = c1; h[2] = c2; h[3] = c3;
      for (int k = 0; k < NT; k++) coefs[k*CW +: CW] = CW'(h[k]);
   endtask

   // One clock: drive after the rising edge, sample after the falling edge.
   task automatic step(input logic v, input logic [DW-1:0] x, input logic r);
      longint acc;
      @(posedge clk);
      #5;
      rst = r;
      in_valid = v;
      in_x = x;
      if (r) begin
         for (int k = 0; k < NT; k++) hist[k] = 0;
         last_y = 0;
         exp_v[iter] = 1'b0;
         exp_y[iter] = 0;
         resume_at = iter + 4;
      end else begin
         if (v) begin
            for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'($signed(x));
            acc = 0;
            for (int k = 0; k < NT; k++) acc += h[k] * hist[k];
            last_y = acc;
         end
         exp_v[iter] = v;
         exp_y[iter] = last_y;
      end
      @(negedge clk);
      #5;
      if (iter >= resume_at) begin
         check(vtag_d, longint'(v_d), longint'(exp_v[iter-2]));
         check(exp_v[iter-2] ? ytag : "R6", longint'(y_d), exp_y[iter-2]);
         check(vtag_s, longint'(v_s), longint'(exp_v[iter-4]));
         check(exp_v[iter-4] ? ytag : "R6", longint'(y_s), exp_y[iter-4]);
      end
      iter++;
   endtask

   initial begin
      load_coefs(3, -2, 5, 7);
      for (int k = 0; k < NT; k++) hist[k] = 0;

      // R7: reset state on both instances
      for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);
      check("R7", longint'(v_d), 0);
      check("R7", longint'(y_d), 0);
      check("R7", longint'(v_s), 0);
      check("R7", longint'(y_s), 0);

      // R9 back-to-back samples, then R2 stream with gaps; R5 valid alignment throughout
      vtag_d = "R5"; vtag_s = "R5";
      for (int i = 0; i < NV; i++) begin
         ytag = (i < 12) ? "R9" : "R2";
         step(VEC[i][16], VEC[i][15:0], 1'b0);
      end

      // R6: drain with invalid garbage on the input
      for (int i = 0; i < 6; i++) step(1'b0, 16'h5A5A, 1'b0);

      // R1 / R3 / R4: single impulse, exact edge of arrival in each mode
      ytag = "R1"; vtag_d = "R3"; vtag_s = "R4";
      step(1'b1, 16'd100, 1'b0);
      for (int i = 0; i < 6; i++) step(1'b0, 16'h1234, 1'b0);

      // R7: reset mid-run with new coefficients; first results use zero history
      for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);
      check("R7", longint'(v_d), 0);
      check("R7", longint'(y_d), 0);
      check("R7", longint'(v_s), 0);
      check("R7", longint'(y_s), 0);
      load_coefs(-32768, -32768, -32768, -32768);
      vtag_d = "R3"; vtag_s = "R4";
      ytag = "R7";
      for (int i = 0; i < 3; i++) step(1'b1, 16'h8000, 1'b0);
      // R8: full-scale sums
      ytag = "R8";
      step(1'b1, 16'h8000, 1'b0);
      for (int i = 0; i < 4; i++) step(1'b1, 16'h7FFF, 1'b0);
      for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b0);

      // R8: the exact extremes were produced
      check("R8", longint'(y_d), -4 * 32767 * 32768);
      check("R8", longint'(y_s), -4 * 32767 * 32768);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule